// File: doc/BRIEF.md
# Split Instruction/Data Translation Lookaside Buffer

This block maps 32-bit virtual addresses onto physical addresses in 4 KiB pages. It keeps two separate direct-mapped translation tables, one serving instruction fetches and one serving loads and stores. Each lookup is combinational from the addressed entry. The physical page number is therefore available in the same cycle as the access, in time for a physically tagged cache to compare it against its line tag.

Software installs a translation in two writes. The first write goes to a staging register and holds the virtual page. The second write carries the physical page, the target table and a write-protect flag, and it commits the entry.

A failed lookup raises one exception per cycle with a cause code. The block also records the virtual address that caused it, for the handler to read.

Top module: `tlb_split`

## Requirements
- R1: On a hit, the physical address output equals {stored physical page, vaddr[11:0]}. The page offset passes through unchanged.
- R2: An entry is selected by vaddr[21:12] and stores vaddr[31:22] as its tag. A lookup hits only if the selected entry is valid and its tag equals vaddr[31:22]. A different tag at the same index misses.
- R3: After reset, every entry in both tables is invalid, so any first access misses.
- R4: Writing with `csr_sel_i`=0 loads the staging virtual page; bits [11:0] of that write are ignored. A staging write alone leaves both tables unchanged. Writing with `csr_sel_i`=1 commits the entry: physical page from bits [31:12], tag and index from the staged page.
- R5: In the commit write, bit 0 selects the table (0 = instruction, 1 = data) and bit 1 sets the write-protect flag. The other table is not modified.
- R6: A fetch (`if_req_i`=1) that misses raises an exception with cause 8.
- R7: A load or store that misses raises an exception with cause 9.
- R8: A store that hits a write-protected data entry raises cause 10. A load that hits the same entry completes with no exception.
- R9: On the clock edge of an exception cycle, `bad_vaddr_o` captures an address. For cause 8 it is {fetch address[31:2], 2'b00}; for causes 9 and 10 it is the full data address. The register holds its value in cycles without an exception.
- R10: When both sides fail in the same cycle, only the data exception is reported.
- R11: A commit updates the table at the clock edge. A lookup in the commit cycle still sees the old entry, and a lookup in the next cycle sees the new one.
- R12: With no exception, `exc_o` is 0 and `exc_cause_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| if_req_i | input | 1 | Fetch access valid |
| if_vaddr_i | input | 32 | Fetch virtual address |
| dm_load_i | input | 1 | Data load strobe |
| dm_store_i | input | 1 | Data store strobe |
| dm_vaddr_i | input | 32 | Data virtual address |
| csr_we_i | input | 1 | Register write strobe |
| csr_sel_i | input | 1 | 0 = staging virtual page, 1 = physical page and commit |
| csr_wdata_i | input | 32 | Register write data |
| if_hit_o | output | 1 | Instruction table hit |
| if_paddr_o | output | 32 | Translated fetch address |
| dm_hit_o | output | 1 | Data table hit |
| dm_paddr_o | output | 32 | Translated data address |
| exc_o | output | 1 | Exception raised this cycle |
| exc_cause_o | output | 4 | Cause code: 8, 9, 10, or 0 when no exception |
| bad_vaddr_o | output | 32 | Captured offending virtual address |

## Verification
The bench targets several corner cases, each paired with the fault it would expose:

- **Index alias.** An address shares an index with a stored page but has a different tag. A design that compared only the index would report a false hit.
- **Write-protected page.** A store to it must fault while a load to it completes. Swapping or merging those codes shows up as a wrong cause.
- **Cross-table leakage.** A page installed in one table is looked up in the other. A design that ignored the table select bit would hit in both tables.
- **Double failure.** Both sides miss in the same cycle. A design with the wrong priority would report cause 8.
- **Commit-cycle lookup.** An early-write design would hit already in the commit cycle.
- **Fetch-address low bits.** A misaligned fetch address is captured with its low bits cleared; a full capture would leave bits [1:0] set.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned VA_W   = 32;
  localparam int unsigned PAGE_W = 12;
  localparam int unsigned IDX_W  = 10;
  localparam int unsigned TAG_W  = VA_W - PAGE_W - IDX_W;
  localparam int unsigned PPN_W  = VA_W - PAGE_W;

  typedef enum logic [3:0] {
    EXC_NONE   = 4'd0,
    EXC_IMISS  = 4'd8,
    EXC_DMISS  = 4'd9,
    EXC_DFAULT = 4'd10
  } exc_cause_e;

  typedef enum logic {
    SIDE_I = 1'b0,
    SIDE_D = 1'b1
  } side_e;
endpackage

// File: rtl/tlb_stage.sv
module tlb_stage
  import tlb_pkg::*;
#(
  parameter int unsigned VAW  = VA_W,
  parameter int unsigned PGW  = PAGE_W,
  parameter int unsigned IDXW = IDX_W,
  localparam int unsigned TAGW = VAW - PGW - IDXW,
  localparam int unsigned PPNW = VAW - PGW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic            sel_i,
  input  logic [VAW-1:0]  wdata_i,
  output logic [1:0]      wr_en_o,
  output logic [IDXW-1:0] wr_idx_o,
  output logic [TAGW-1:0] wr_tag_o,
  output logic [PPNW-1:0] wr_ppn_o,
  output logic            wr_ro_o
);
  logic [PPNW-1:0] stage_vpn_q;
  logic            commit;
  logic            unused_w;

  assign unused_w = ^wdata_i[PGW-1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                stage_vpn_q <= '0;
    else if (we_i && !sel_i)    stage_vpn_q <= wdata_i[VAW-1:PGW];
  end

  assign commit   = we_i && sel_i;
  assign wr_en_o  = {commit && wdata_i[0], commit && !wdata_i[0]};
  assign wr_idx_o = stage_vpn_q[IDXW-1:0];
  assign wr_tag_o = stage_vpn_q[PPNW-1:IDXW];
  assign wr_ppn_o = wdata_i[VAW-1:PGW];
  assign wr_ro_o  = wdata_i[1];

  // R5: at most one table written, only by a commit write
  p_commit_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en_o) && ((wr_en_o != 2'b00) -> (we_i && sel_i)));
endmodule

// File: rtl/tlb_table.sv
module tlb_table
  import tlb_pkg::*;
#(
  parameter int unsigned IDXW = IDX_W,
  parameter int unsigned TAGW = TAG_W,
  parameter int unsigned PPNW = PPN_W,
  localparam int unsigned DEPTH = 1 << IDXW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [IDXW-1:0] wr_idx_i,
  input  logic [TAGW-1:0] wr_tag_i,
  input  logic [PPNW-1:0] wr_ppn_i,
  input  logic            wr_ro_i,
  input  logic [IDXW-1:0] rd_idx_i,
  input  logic [TAGW-1:0] rd_tag_i,
  output logic            hit_o,
  output logic [PPNW-1:0] ppn_o,
  output logic            ro_o
);
  logic [DEPTH-1:0] valid_q;
  logic [TAGW-1:0]  tag_q [DEPTH];
  logic [PPNW-1:0]  ppn_q [DEPTH];
  logic [DEPTH-1:0] ro_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i] <= wr_tag_i;
      ppn_q[wr_idx_i] <= wr_ppn_i;
      ro_q[wr_idx_i]  <= wr_ro_i;
    end
  end

  assign hit_o = valid_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);
  assign ppn_o = ppn_q[rd_idx_i];
  assign ro_o  = ro_q[rd_idx_i];

  // R11: a committed entry is valid from the next cycle on
  p_commit_visible_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> valid_q[$past(wr_idx_i)]);
endmodule

// File: rtl/tlb_exc.sv
module tlb_exc
  import tlb_pkg::*;
#(
  parameter int unsigned VAW = VA_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           if_req_i,
  input  logic           if_hit_i,
  input  logic [VAW-1:0] if_vaddr_i,
  input  logic           dm_load_i,
  input  logic           dm_store_i,
  input  logic           dm_hit_i,
  input  logic           dm_ro_i,
  input  logic [VAW-1:0] dm_vaddr_i,
  output logic           exc_o,
  output logic [3:0]     exc_cause_o,
  output logic [VAW-1:0] bad_vaddr_o
);
  exc_cause_e cause;
  logic       dm_acc;

  assign dm_acc = dm_load_i || dm_store_i;

  always_comb begin
    cause = EXC_NONE;
    if (dm_acc && !dm_hit_i)                     cause = EXC_DMISS;
    else if (dm_store_i && dm_hit_i && dm_ro_i)  cause = EXC_DFAULT;
    else if (if_req_i && !if_hit_i)              cause = EXC_IMISS;
  end

  assign exc_o       = (cause != EXC_NONE);
  assign exc_cause_o = cause;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                bad_vaddr_o <= '0;
    else if (cause == EXC_IMISS) bad_vaddr_o <= {if_vaddr_i[VAW-1:2], 2'b00};
    else if (cause != EXC_NONE)  bad_vaddr_o <= dm_vaddr_i;
  end

  // R8: write-protect fault only for a store that hit
  p_fault_store_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_cause_o == 4'd10) |-> (dm_store_i && dm_hit_i));
  // R10: data failure wins over fetch failure
  p_data_prio_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dm_acc && !dm_hit_i && if_req_i && !if_hit_i) |-> (exc_cause_o == 4'd9));
  // R9: fetch capture is word aligned
  p_bad_word_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_o && exc_cause_o == 4'd8) |=> (bad_vaddr_o[1:0] == 2'b00));
  // R9: capture holds without an exception
  p_bad_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_o |=> $stable(bad_vaddr_o));
  // R12: flag and code agree
  p_cause_flag_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o == (exc_cause_o != 4'd0));
endmodule

// File: rtl/tlb_split.sv
module tlb_split
  import tlb_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        if_req_i,
  input  logic [31:0] if_vaddr_i,
  input  logic        dm_load_i,
  input  logic        dm_store_i,
  input  logic [31:0] dm_vaddr_i,
  input  logic        csr_we_i,
  input  logic        csr_sel_i,
  input  logic [31:0] csr_wdata_i,
  output logic        if_hit_o,
  output logic [31:0] if_paddr_o,
  output logic        dm_hit_o,
  output logic [31:0] dm_paddr_o,
  output logic        exc_o,
  output logic [3:0]  exc_cause_o,
  output logic [31:0] bad_vaddr_o
);
  localparam int unsigned NSIDE = 2;

  logic [1:0]       wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [TAG_W-1:0] wr_tag;
  logic [PPN_W-1:0] wr_ppn;
  logic             wr_ro;

  logic [VA_W-1:0]  lk_va  [NSIDE];
  logic             lk_hit [NSIDE];
  logic [PPN_W-1:0] lk_ppn [NSIDE];
  logic             lk_ro  [NSIDE];
  logic             unused_ro;

  tlb_stage u_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (csr_we_i),
    .sel_i    (csr_sel_i),
    .wdata_i  (csr_wdata_i),
    .wr_en_o  (wr_en),
    .wr_idx_o (wr_idx),
    .wr_tag_o (wr_tag),
    .wr_ppn_o (wr_ppn),
    .wr_ro_o  (wr_ro)
  );

  assign lk_va[SIDE_I] = if_vaddr_i;
  assign lk_va[SIDE_D] = dm_vaddr_i;

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    tlb_table u_table (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_en[g]),
      .wr_idx_i (wr_idx),
      .wr_tag_i (wr_tag),
      .wr_ppn_i (wr_ppn),
      .wr_ro_i  (wr_ro),
      .rd_idx_i (lk_va[g][PAGE_W+IDX_W-1:PAGE_W]),
      .rd_tag_i (lk_va[g][VA_W-1:PAGE_W+IDX_W]),
      .hit_o    (lk_hit[g]),
      .ppn_o    (lk_ppn[g]),
      .ro_o     (lk_ro[g])
    );
  end

  assign unused_ro  = lk_ro[SIDE_I];
  assign if_hit_o   = lk_hit[SIDE_I];
  assign if_paddr_o = {lk_ppn[SIDE_I], if_vaddr_i[PAGE_W-1:0]};
  assign dm_hit_o   = lk_hit[SIDE_D];
  assign dm_paddr_o = {lk_ppn[SIDE_D], dm_vaddr_i[PAGE_W-1:0]};

  tlb_exc u_exc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .if_req_i    (if_req_i),
    .if_hit_i    (lk_hit[SIDE_I]),
    .if_vaddr_i  (if_vaddr_i),
    .dm_load_i   (dm_load_i),
    .dm_store_i  (dm_store_i),
    .dm_hit_i    (lk_hit[SIDE_D]),
    .dm_ro_i     (lk_ro[SIDE_D]),
    .dm_vaddr_i  (dm_vaddr_i),
    .exc_o       (exc_o),
    .exc_cause_o (exc_cause_o),
    .bad_vaddr_o (bad_vaddr_o)
  );

  // R1: offset bits pass through untranslated on both sides
  p_offset_pass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (if_paddr_o[11:0] == if_vaddr_i[11:0]) && (dm_paddr_o[11:0] == dm_vaddr_i[11:0]));
  // R6: a missing fetch with a clean data side reports cause 8
  p_imiss_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (if_req_i && !if_hit_o && !dm_load_i && !dm_store_i) |-> (exc_cause_o == 4'd8));
endmodule

// File: tb/tlb_split_tb.sv
module tlb_split_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        if_req = 1'b0;
  logic [31:0] if_va = '0;
  logic        dm_ld = 1'b0, dm_st = 1'b0;
  logic [31:0] dm_va = '0;
  logic        csr_we = 1'b0, csr_sel = 1'b0;
  logic [31:0] csr_wd = '0;
  logic        if_hit, dm_hit, exc;
  logic [31:0] if_pa, dm_pa, bad_va;
  logic [3:0]  cause;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tlb_split u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .if_req_i(if_req), .if_vaddr_i(if_va),
    .dm_load_i(dm_ld), .dm_store_i(dm_st), .dm_vaddr_i(dm_va),
    .csr_we_i(csr_we), .csr_sel_i(csr_sel), .csr_wdata_i(csr_wd),
    .if_hit_o(if_hit), .if_paddr_o(if_pa),
    .dm_hit_o(dm_hit), .dm_paddr_o(dm_pa),
    .exc_o(exc), .exc_cause_o(cause), .bad_vaddr_o(bad_va)
  );

  typedef struct packed {
    logic        is_d;
    logic        st;
    logic [31:0] va;
    logic        hit;
    logic [3:0]  cause;
    logic [19:0] ppn;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 32'h0040_3ABC, 1'b1, 4'd0,  20'h12345},
    '{1'b0, 1'b0, 32'h0080_3ABE, 1'b0, 4'd8,  20'h00000},
    '{1'b1, 1'b0, 32'h8010_7FFC, 1'b1, 4'd0,  20'hABCDE},
    '{1'b1, 1'b1, 32'h8010_7004, 1'b1, 4'd0,  20'hABCDE},
    '{1'b1, 1'b0, 32'h0010_7000, 1'b0, 4'd9,  20'h00000},
    '{1'b1, 1'b1, 32'h0000_5010, 1'b1, 4'd10, 20'h05555},
    '{1'b1, 1'b0, 32'h0000_5010, 1'b1, 4'd0,  20'h05555},
    '{1'b0, 1'b0, 32'h8010_7002, 1'b0, 4'd8,  20'h00000},
    '{1'b1, 1'b0, 32'h0040_3000, 1'b0, 4'd9,  20'h00000},
    '{1'b1, 1'b1, 32'h8090_7000, 1'b0, 4'd9,  20'h00000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tlb_write(input logic [31:0] va, input logic [31:0] pa);
    @(negedge clk); csr_we = 1'b1; csr_sel = 1'b0; csr_wd = va;
    @(negedge clk); csr_sel = 1'b1; csr_wd = pa;
    @(negedge clk); csr_we = 1'b0; csr_sel = 1'b0; csr_wd = '0;
  endtask

  task automatic idle();
    if_req = 1'b0; dm_ld = 1'b0; dm_st = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 idle, R3 reset state
    #1;
    chk("R12 idle exc", {31'd0, exc}, 32'd0);
    chk("R12 idle cause", {28'd0, cause}, 32'd0);
    chk("R9 reset bad_vaddr", bad_va, 32'd0);
    @(negedge clk); if_req = 1'b1; if_va = 32'h0000_0000; #1;
    chk("R3 reset itlb miss", {28'd0, cause}, 32'd8);
    idle(); @(negedge clk); dm_ld = 1'b1; dm_va = 32'h0000_0000; #1;
    chk("R3 reset dtlb miss", {28'd0, cause}, 32'd9);
    idle();

    // R4: staging write alone commits nothing
    @(negedge clk); csr_we = 1'b1; csr_sel = 1'b0; csr_wd = 32'h0040_3000;
    @(negedge clk); csr_we = 1'b0; if_req = 1'b1; if_va = 32'h0040_3000; #1;
    chk("R4 staging only no hit", {31'd0, if_hit}, 32'd0);
    idle();

    tlb_write(32'h0040_3000, 32'h1234_5000);
    tlb_write(32'h8010_7000, 32'hABCD_E001);
    tlb_write(32'h0000_5000, 32'h0555_5003);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      held = bad_va;
      if (VEC[i].is_d) begin
        dm_va = VEC[i].va; dm_ld = !VEC[i].st; dm_st = VEC[i].st;
      end else begin
        if_va = VEC[i].va; if_req = 1'b1;
      end
      #1;
      chk($sformatf("R2/R5/R6/R7/R8 vec%0d cause", i), {28'd0, cause}, {28'd0, VEC[i].cause});
      chk($sformatf("R2/R5 vec%0d hit", i),
          {31'd0, VEC[i].is_d ? dm_hit : if_hit}, {31'd0, VEC[i].hit});
      if (VEC[i].hit)
        chk($sformatf("R1 vec%0d paddr", i), VEC[i].is_d ? dm_pa : if_pa,
            {VEC[i].ppn, VEC[i].va[11:0]});
      @(negedge clk);
      if (VEC[i].cause != 4'd0)
        chk($sformatf("R9 vec%0d bad_vaddr", i), bad_va,
            VEC[i].is_d ? VEC[i].va : {VEC[i].va[31:2], 2'b00});
      else
        chk($sformatf("R9 vec%0d bad_vaddr hold", i), bad_va, held);
      idle();
    end

    // R10: both sides miss, data reported
    @(negedge clk);
    if_req = 1'b1; if_va = 32'h0FF0_1000; dm_ld = 1'b1; dm_va = 32'h0FF0_2344; #1;
    chk("R10 priority cause", {28'd0, cause}, 32'd9);
    @(negedge clk);
    chk("R10 priority bad_vaddr", bad_va, 32'h0FF0_2344);
    idle();

    // R11: commit-cycle lookup sees old, next cycle new
    @(negedge clk); csr_we = 1'b1; csr_sel = 1'b0; csr_wd = 32'h0300_9000;
    @(negedge clk); csr_sel = 1'b1; csr_wd = 32'h7777_7001;
    dm_ld = 1'b1; dm_va = 32'h0300_9010; #1;
    chk("R11 commit cycle miss", {31'd0, dm_hit}, 32'd0);
    @(negedge clk); csr_we = 1'b0; csr_sel = 1'b0; #1;
    chk("R11 next cycle hit", {31'd0, dm_hit}, 32'd1);
    chk("R11 next cycle paddr", dm_pa, 32'h7777_7010);
    idle();

    // R4: offset bits of staging write ignored
    tlb_write(32'h00C0_0FFF, 32'h0BEE_F000);
    @(negedge clk); if_req = 1'b1; if_va = 32'h00C0_0123; #1;
    chk("R4 offset ignored hit", {31'd0, if_hit}, 32'd1);
    chk("R4 offset ignored paddr", if_pa, 32'h0BEE_F123);
    idle();

    // R12 after activity
    @(negedge clk); #1;
    chk("R12 quiet cause", {27'd0, exc, cause}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule